// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

This block is a software-armed watchdog. A prescaler divides the reference clock down to a one-cycle tick once per second. An 8-bit control word holds three things: a run bit, a sticky timeout flag that software can only read, and a 6-bit count of seconds. Software arms the timer by writing the word with the run bit set. It keeps the system alive by rewriting the word before the count runs out.

When the count runs out, the block pulls an open-drain reset line low for a fixed number of milliseconds. In the same cycle it raises a one-cycle strobe that tells the frequency-select logic to return to its hardware-strapped setting. The timer then stops, clears its run bit and sets the sticky flag. It stays stopped until software arms it again.

Top module: `wdog_rst_pulse`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `rst_pull_low` is 0 (line released) and `strap_restore` is 0.
- R2: `rd_data` is {run bit in bit 7, timeout flag in bit 6, seconds count in bits 5:0}. The run bit and the count read back as last written, except that a timeout clears the run bit.
- R3: A write with bit 7 = 1 and count N arms the timer. The timeout happens at the clock edge exactly (N+1)*CLK_HZ cycles after the write edge, and not before.
- R4: At timeout, `rst_pull_low` goes to 1 for exactly CLK_HZ*PULSE_MS/1000 cycles and is 0 at all other times.
- R5: `strap_restore` is high for exactly one cycle, which is the first cycle of the reset pulse.
- R6: At timeout the flag (bit 6) sets and the run bit clears. No further pulse follows until the timer is re-armed.
- R7: A write with bit 7 = 0 stops the timer with no timeout and leaves the flag unchanged.
- R8: A write with bit 7 = 1 clears the flag and restarts the full period from the new count. Rewriting it while the timer runs therefore postpones the timeout.
- R9: A write that lands on the same edge as a pending expiry wins. No pulse is produced, and the new period starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write; bit 6 is ignored |
| rd_data | output | 8 | Current control word with the timeout flag |
| rst_pull_low | output | 1 | 1 = drive the reset line low, 0 = release it |
| strap_restore | output | 1 | One-cycle request to fall back to strapped clock settings |

## Verification
The bench arms the timer with a count of zero and with a non-zero count, and samples the cycle just before and just after the expiry edge. A prescaler or down-counter that is off by one would fire a cycle early or a whole second early or late. It measures the pulse at both ends, so a pulse one cycle long or short shows up, and it checks that the restore strobe does not linger. Further tests cover a disabling write, a rearming write in mid-period and a write landing exactly on the expiry edge. A design that let the flag be cleared by a stop, that ignored the kick, or that let expiry beat a simultaneous write would fire a stray pulse or show the wrong flag.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  // Reference cycles in one second of the watchdog time base.
  function automatic int unsigned f_sec_cycles(input int unsigned clk_hz);
    return (clk_hz < 2) ? 2 : clk_hz;
  endfunction

  // Reference cycles in the reset pulse, never less than one.
  function automatic int unsigned f_pulse_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
    int unsigned c;
    c = (clk_hz * ms) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/wdr_prescaler.sv
module wdr_prescaler #(
  parameter int unsigned DIV = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || !run)    cnt <= '0;
    else if (cnt == W'(DIV - 1)) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick = run && !restart && (cnt == W'(DIV - 1));

  // R3: ticks are at least one second apart, never back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R8: a write restarts the second from zero
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] remaining;

  assign expire = running && tick && (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      running   <= 1'b0;
    end else if (load) begin
      remaining <= load_val;
      running   <= 1'b1;
    end else if (stop) begin
      remaining <= '0;
      running   <= 1'b0;
    end else if (expire) begin
      running   <= 1'b0;
    end else if (running && tick) begin
      remaining <= remaining - 1'b1;
    end
  end

  // R6: the timer halts after expiry
  p_halt_after_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !running);
  // R8: an arming write takes the new count and runs
  p_load_takes_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running && remaining == $past(load_val)));
  // R7: a stop never yields an expiry on the next cycle
  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !expire);
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
  parameter int unsigned PW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic low
);
  localparam int unsigned CW = $clog2(PW + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(PW);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign low = (cnt != '0);

  // Checker-side length counter for the pulse window
  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (low) run_len <= run_len + 1'b1;
    else          run_len <= '0;
  end

  // R4: each pulse lasts exactly PW cycles
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low) |-> (run_len == CW'(PW)));
  // R4: firing drives the line low on the next cycle
  p_fire_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> low);
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned CLK_HZ   = 2000,
  parameter int unsigned PULSE_MS = 4,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CNT_W+1:0]     wr_data,
  output logic [CNT_W+1:0]     rd_data,
  output logic                 rst_pull_low,
  output logic                 strap_restore
);
  import wdr_pkg::*;

  localparam int unsigned REG_W   = CNT_W + 2;
  localparam int unsigned SEC_CYC = f_sec_cycles(CLK_HZ);
  localparam int unsigned PW_CYC  = f_pulse_cycles(CLK_HZ, PULSE_MS);
  localparam int unsigned RUN_B   = REG_W - 1;

  logic             run_q;
  logic             flag_q;
  logic [CNT_W-1:0] secs_q;
  logic             restore_q;

  // Named internal events
  logic arm_wr;
  logic stop_wr;
  logic sec_tick;
  logic timer_on;
  logic expire;

  assign arm_wr  = wr_en &&  wr_data[RUN_B];
  assign stop_wr = wr_en && !wr_data[RUN_B];

  wdr_prescaler #(.DIV(SEC_CYC)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_en),
    .run     (timer_on),
    .tick    (sec_tick)
  );

  wdr_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm_wr),
    .stop     (stop_wr),
    .load_val (wr_data[CNT_W-1:0]),
    .tick     (sec_tick),
    .running  (timer_on),
    .expire   (expire)
  );

  wdr_pulse #(.PW(PW_CYC)) u_pls (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (expire),
    .low   (rst_pull_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      flag_q    <= 1'b0;
      secs_q    <= '0;
      restore_q <= 1'b0;
    end else begin
      restore_q <= expire;
      if (wr_en) begin
        run_q  <= wr_data[RUN_B];
        secs_q <= wr_data[CNT_W-1:0];
        if (wr_data[RUN_B]) flag_q <= 1'b0;
      end else if (expire) begin
        run_q  <= 1'b0;
        flag_q <= 1'b1;
      end
    end
  end

  assign rd_data       = {run_q, flag_q, secs_q};
  assign strap_restore = restore_q;

  // R5: the restore request is a single-cycle strobe
  p_restore_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strap_restore |=> !strap_restore);
  // R5: the restore strobe and the pulse start together
  p_restore_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strap_restore |-> rst_pull_low);
  // R6: expiry sets the flag and drops the run bit
  p_expire_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag_q && !run_q));
  // R7: a stopping write leaves the flag alone
  p_stop_keeps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (flag_q == $past(flag_q)));
  // R9: a write in the expiry cycle suppresses the pulse start
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !expire);
endmodule

// File: tb/wdog_rst_pulse_tb_top.sv
module wdog_rst_pulse_tb_top;
  localparam int TPS = 2000;
  localparam int PW  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_pull_low;
  logic       strap_restore;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_rst_pulse #(.CLK_HZ(TPS), .PULSE_MS(4), .CNT_W(6)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .rst_pull_low  (rst_pull_low),
    .strap_restore (strap_restore)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write is sampled at the next rising edge.
  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 line", rst_pull_low, 1'b0);
    chk("R1 restore", strap_restore, 1'b0);
  endtask

  task automatic t_zero_count;
    wr(8'h80);
    step(TPS - 1);
    chk("R3 no early pulse", rst_pull_low, 1'b0);
    chk("R2 readback", rd_data, 8'h80);
    step(1);
    chk("R4 pulse start", rst_pull_low, 1'b1);
    chk("R5 restore high", strap_restore, 1'b1);
    chk("R6 flag set run cleared", rd_data, 8'h40);
    step(1);
    chk("R5 restore one cycle", strap_restore, 1'b0);
    step(PW - 2);
    chk("R4 pulse last cycle", rst_pull_low, 1'b1);
    step(1);
    chk("R4 pulse released", rst_pull_low, 1'b0);
    step(2 * TPS);
    chk("R6 no second pulse", rst_pull_low, 1'b0);
    chk("R6 flag sticky", rd_data, 8'h40);
    wr(8'h00);
    chk("R7 stop keeps flag", rd_data, 8'h40);
  endtask

  task automatic t_count_n;
    wr(8'h82);
    chk("R8 flag cleared by arm", rd_data, 8'h82);
    step(3 * TPS - 1);
    chk("R3 count 2 not early", rst_pull_low, 1'b0);
    step(1);
    chk("R3 count 2 fires", rst_pull_low, 1'b1);
    chk("R6 run bit cleared", rd_data, 8'h42);
    step(PW + 2);
  endtask

  task automatic t_disable;
    int seen;
    wr(8'h81);
    step(TPS);
    wr(8'h01);
    seen = 0;
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk);
      if (rst_pull_low) seen++;
    end
    chk("R7 stopped no pulse", seen, 0);
    chk("R7 readback after stop", rd_data, 8'h01);
  endtask

  task automatic t_kick;
    wr(8'h81);
    step(TPS + TPS / 2);
    chk("R8 before kick", rst_pull_low, 1'b0);
    wr(8'h81);
    step(TPS);
    chk("R8 old deadline passed", rst_pull_low, 1'b0);
    step(TPS - 1);
    chk("R8 new deadline not early", rst_pull_low, 1'b0);
    step(1);
    chk("R8 new deadline fires", rst_pull_low, 1'b1);
    step(PW + 2);
  endtask

  task automatic t_collide;
    wr(8'h80);
    step(TPS - 1);
    wr(8'h81);
    chk("R9 write wins no pulse", rst_pull_low, 1'b0);
    chk("R9 no restore", strap_restore, 1'b0);
    chk("R9 readback", rd_data, 8'h81);
    step(2 * TPS - 1);
    chk("R9 restart not early", rst_pull_low, 1'b0);
    step(1);
    chk("R9 restart fires", rst_pull_low, 1'b1);
    step(PW + 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_zero_count();
    t_count_n();
    t_disable();
    t_kick();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule